// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 16-bit virtual address into a physical address by reading two page-table entries from memory, one after the other. The page-number part of the address is cut into an upper index into the root table and a lower index into a leaf table. The root table is located by a base register. A valid root entry gives the base of a leaf table. A valid leaf entry gives the frame number. The frame number is placed above the page offset, which passes through unchanged, to form the physical address.

A client offers an address on the request port and waits for a one-cycle response. The response carries either the physical address or a fault code that says which level held an invalid entry. The walker shares a read port with memory. It raises a one-cycle read strobe and then waits for however many cycles memory needs to return data with a valid flag. Only one translation is in flight at a time.

The controller moves through six named states. IDLE accepts a request (IDLE→READ_L1). READ_L1 issues the root read (READ_L1→WAIT_L1). WAIT_L1 waits for data. It goes on to READ_L2 if the root entry is valid, or to DONE with a root fault if it is not. READ_L2 issues the leaf read (READ_L2→WAIT_L2). WAIT_L2 waits for data and then goes to DONE, with either a frame or a leaf fault. DONE presents the response for one cycle and returns to IDLE (DONE→IDLE).

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is in IDLE: `req_ready` is 1, and `mem_rd_en` and `rsp_valid` are 0.
- R2: A request is taken only on a cycle where `req_ready` is 1, which happens only in IDLE. `req_ready` stays 0 from acceptance until the response. Changes on `req_valid`/`req_vaddr` while busy have no effect on the result.
- R3: The virtual address fields are: bits 15:13 are the root index, bits 12:10 are the leaf index, and bits 9:0 are the page offset.
- R4: The first read goes to `ptbr` + root index. `ptbr` is sampled when the request is accepted, so later changes to it do not affect the walk in progress.
- R5: In an entry, bit 15 is the valid flag. In a valid root entry, bits 14:0 give the leaf table base, and the second read goes to that base + leaf index.
- R6: Each read is a `mem_rd_en` pulse of exactly one cycle. The walker then waits any number of cycles for `mem_rd_valid`. A `mem_rd_valid` that arrives while no read is pending is ignored.
- R7: A root entry with bit 15 clear ends the walk with `rsp_fault` = 2'b01 after exactly one read. No second read is issued.
- R8: A leaf entry with bit 15 clear ends the walk with `rsp_fault` = 2'b10 after exactly two reads.
- R9: On success, `rsp_fault` = 2'b00 and `rsp_paddr` = {leaf entry bits 4:0, offset bits 9:0}. The other bits of the leaf entry are ignored.
- R10: `rsp_valid` is a one-cycle pulse, after which `req_ready` is 1 again. When a fault is reported, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| ptbr | input | 16 | Word address of the root table |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 16 | Word address of the entry to read |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | 16 | Page-table entry returned by memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 15 | Physical address (0 when a fault is reported) |
| rsp_fault | output | 2 | 00 none, 01 root entry invalid, 10 leaf entry invalid |

## Verification
The embedded assertions check the handshake shape on every cycle:
- read strobes and response strobes last exactly one cycle;
- acceptance drops `req_ready` until a response arrives;
- the fault code never takes its unused value;
- a fault always comes with a zero physical address.

Only the bench's scenarios can show that the walk is correct:
- read addresses are built from the right index and base;
- the level that faulted is the one that held the invalid entry;
- a root fault skips the second read;
- the frame bits are combined correctly with the offset.

They can also show that a changed base register, a request that changes while the walker is busy, and a stray data-valid in idle all leave the result unchanged.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_READ_L1 = 3'd1,
        S_WAIT_L1 = 3'd2,
        S_READ_L2 = 3'd3,
        S_WAIT_L2 = 3'd4,
        S_DONE    = 3'd5
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_L1   = 2'b01,
        FLT_L2   = 2'b10
    } walk_fault_t;
endpackage

// File: rtl/pt_va_split.sv
`timescale 1ns/1ps
module pt_va_split #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 10,
    parameter int L1_W  = 3,
    parameter int L2_W  = 3
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [L1_W-1:0]  idx_root,
    output logic [L2_W-1:0]  idx_leaf,
    output logic [OFF_W-1:0] offset
);
    localparam int LEAF_LO = OFF_W;
    localparam int ROOT_LO = OFF_W + L2_W;

    always_comb begin
        offset   = vaddr[OFF_W-1:0];
        idx_leaf = vaddr[LEAF_LO +: L2_W];
        idx_root = vaddr[ROOT_LO +: L1_W];
    end
endmodule

// File: rtl/pt_entry_decode.sv
`timescale 1ns/1ps
module pt_entry_decode #(
    parameter int PTE_W   = 16,
    parameter int FRAME_W = 5,
    parameter int MA_W    = 16
) (
    input  logic [PTE_W-1:0]   pte,
    output logic               present,
    output logic [MA_W-1:0]    next_base,
    output logic [FRAME_W-1:0] frame
);
    localparam int BASE_W = PTE_W - 1;

    always_comb begin
        present   = pte[PTE_W-1];
        next_base = MA_W'(pte[BASE_W-1:0]);
        frame     = pte[FRAME_W-1:0];
    end
endmodule

// File: rtl/pt_walk_fsm.sv
`timescale 1ns/1ps
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 10,
    parameter int L1_W    = 3,
    parameter int L2_W    = 3,
    parameter int FRAME_W = 5,
    parameter int MA_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_W-1:0]            req_vaddr,
    output logic                       req_ready,
    input  logic [MA_W-1:0]            ptbr,
    output logic [VA_W-1:0]            vaddr_q,
    input  logic [L1_W-1:0]            idx_root,
    input  logic [L2_W-1:0]            idx_leaf,
    input  logic [OFF_W-1:0]           offset,
    output logic                       mem_rd_en,
    output logic [MA_W-1:0]            mem_rd_addr,
    input  logic                       mem_rd_valid,
    input  logic                       ent_present,
    input  logic [MA_W-1:0]            ent_base,
    input  logic [FRAME_W-1:0]         ent_frame,
    output logic                       rsp_valid,
    output logic [FRAME_W+OFF_W-1:0]   rsp_paddr,
    output logic [1:0]                 rsp_fault
);
    localparam int PA_W = FRAME_W + OFF_W;

    walk_state_t          state_q, state_nx;
    logic [MA_W-1:0]      root_q;
    logic [MA_W-1:0]      leaf_base_q;
    logic [FRAME_W-1:0]   frame_q;
    walk_fault_t          fault_q;

    // next-state selection
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_nx = S_READ_L1;
            S_READ_L1: state_nx = S_WAIT_L1;
            S_WAIT_L1: if (mem_rd_valid) state_nx = ent_present ? S_READ_L2 : S_DONE;
            S_READ_L2: state_nx = S_WAIT_L2;
            S_WAIT_L2: if (mem_rd_valid) state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // walk context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            root_q      <= '0;
            leaf_base_q <= '0;
            frame_q     <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    root_q  <= ptbr;
                    frame_q <= '0;
                    fault_q <= FLT_NONE;
                end
                S_WAIT_L1: if (mem_rd_valid) begin
                    if (ent_present) leaf_base_q <= ent_base;
                    else             fault_q     <= FLT_L1;
                end
                S_WAIT_L2: if (mem_rd_valid) begin
                    if (ent_present) frame_q <= ent_frame;
                    else             fault_q <= FLT_L2;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == S_IDLE);
        mem_rd_en   = (state_q == S_READ_L1) || (state_q == S_READ_L2);
        mem_rd_addr = (state_q == S_READ_L2) ? (leaf_base_q + MA_W'(idx_leaf))
                                             : (root_q + MA_W'(idx_root));
        rsp_valid   = (state_q == S_DONE);
        rsp_fault   = fault_q;
        rsp_paddr   = (fault_q == FLT_NONE) ? {frame_q, offset} : PA_W'(0);
    end

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'b11));

    // R10
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (rsp_paddr == '0));
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 10,
    parameter int L1_W    = 3,
    parameter int L2_W    = 3,
    parameter int PTE_W   = 16,
    parameter int FRAME_W = 5,
    parameter int MA_W    = 16,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              req_ready,
    input  logic [MA_W-1:0]   ptbr,
    output logic              mem_rd_en,
    output logic [MA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [PTE_W-1:0]  mem_rd_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault
);
    logic [VA_W-1:0]    vaddr_q;
    logic [L1_W-1:0]    idx_root;
    logic [L2_W-1:0]    idx_leaf;
    logic [OFF_W-1:0]   offset;
    logic               ent_present;
    logic [MA_W-1:0]    ent_base;
    logic [FRAME_W-1:0] ent_frame;

    pt_va_split #(.VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W)) u_split (
        .vaddr    (vaddr_q),
        .idx_root (idx_root),
        .idx_leaf (idx_leaf),
        .offset   (offset)
    );

    pt_entry_decode #(.PTE_W(PTE_W), .FRAME_W(FRAME_W), .MA_W(MA_W)) u_decode (
        .pte       (mem_rd_data),
        .present   (ent_present),
        .next_base (ent_base),
        .frame     (ent_frame)
    );

    pt_walk_fsm #(
        .VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W),
        .FRAME_W(FRAME_W), .MA_W(MA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_vaddr    (req_vaddr),
        .req_ready    (req_ready),
        .ptbr         (ptbr),
        .vaddr_q      (vaddr_q),
        .idx_root     (idx_root),
        .idx_leaf     (idx_leaf),
        .offset       (offset),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .ent_present  (ent_present),
        .ent_base     (ent_base),
        .ent_frame    (ent_frame),
        .rsp_valid    (rsp_valid),
        .rsp_paddr    (rsp_paddr),
        .rsp_fault    (rsp_fault)
    );
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        req_ready;
    logic [15:0] ptbr = 16'd16;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic [14:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_ready(req_ready), .ptbr(ptbr), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
    );

    // memory image
    logic [15:0] mem [0:255];
    int          lat_cfg = 1;
    bit          stray_req = 0;
    int          rd_total = 0;
    logic [15:0] rd_log [0:3];
    logic [15:0] pend_addr = '0;
    int          pend_cnt = 0;

    function automatic logic [4:0] frame_of(int i, int j);
        return 5'(((i * 8 + j) * 3 + 1) % 32);
    endfunction

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
        for (int i = 0; i < 8; i++) begin
            mem[16 + i] = (i == 5) ? 16'h0070 : (16'h8000 | 16'(64 + 8 * i));
            for (int j = 0; j < 8; j++) begin
                if (((i + j) % 7) == 3)
                    mem[64 + 8 * i + j] = 16'(frame_of(i, j)) | 16'h7C00;
                else
                    mem[64 + 8 * i + j] = 16'h8000 | 16'(j << 9) | 16'(frame_of(i, j));
            end
        end
    end

    // memory responder, acting away from the active edge
    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        if (rst_n) begin
            if (mem_rd_en) begin
                pend_addr = mem_rd_addr;
                pend_cnt  = lat_cfg;
                rd_log[rd_total % 4] = mem_rd_addr;
                rd_total++;
            end else if (pend_cnt != 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem[pend_addr[7:0]];
                end
            end else if (stray_req) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = 16'hFFFF;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // one translation with expected values derived from the requirements
    task automatic translate(input logic [15:0] va, input int lat, input bit disturb);
        logic [2:0]  p1, p2;
        logic [15:0] a1, a2, e1, e2;
        logic [14:0] exp_pa;
        logic [1:0]  exp_flt;
        int          exp_reads, start_rd, waited;
        bit          busy_ok, got;
        p1 = va[15:13];                      // R3
        p2 = va[12:10];
        a1 = ptbr + 16'(p1);                 // R4
        e1 = mem[a1[7:0]];
        a2 = {1'b0, e1[14:0]} + 16'(p2);     // R5
        e2 = mem[a2[7:0]];
        if (!e1[15]) begin
            exp_flt = 2'b01; exp_pa = '0; exp_reads = 1;
        end else if (!e2[15]) begin
            exp_flt = 2'b10; exp_pa = '0; exp_reads = 2;
        end else begin
            exp_flt = 2'b00; exp_pa = {e2[4:0], va[9:0]}; exp_reads = 2;
        end

        lat_cfg  = lat;
        start_rd = rd_total;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        if (disturb) begin
            req_vaddr = ~va;
            ptbr      = 16'h0038;
        end else begin
            req_valid = 1'b0;
        end
        busy_ok = 1; got = 0; waited = 0;
        while (!got && waited < 100) begin
            if (rsp_valid) got = 1;
            else begin
                if (req_ready) busy_ok = 0;
                @(negedge clk);
                waited++;
            end
        end
        req_valid = 1'b0;
        ptbr      = 16'd16;
        check(got, "R10 response arrives", int'(got), 1);
        check(busy_ok, "R2 req_ready low while busy", int'(busy_ok), 1);
        check(rsp_fault == exp_flt, exp_flt == 2'b01 ? "R7 fault code" :
              (exp_flt == 2'b10 ? "R8 fault code" : "R9 fault code"),
              int'(rsp_fault), int'(exp_flt));
        check(rsp_paddr == exp_pa, exp_flt == 2'b00 ? "R9 physical address" : "R10 paddr zero on fault",
              int'(rsp_paddr), int'(exp_pa));
        check((rd_total - start_rd) == exp_reads, "R7 R8 read count",
              rd_total - start_rd, exp_reads);
        check(rd_log[start_rd % 4] == a1, "R4 root read address",
              int'(rd_log[start_rd % 4]), int'(a1));
        if (exp_reads == 2)
            check(rd_log[(start_rd + 1) % 4] == a2, "R5 leaf read address",
                  int'(rd_log[(start_rd + 1) % 4]), int'(a2));
        @(negedge clk);
        check(!rsp_valid && req_ready, "R10 single-cycle response",
              int'({rsp_valid, req_ready}), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        summary();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        // R1
        check(req_ready && !mem_rd_en && !rsp_valid, "R1 reset state",
              int'({req_ready, mem_rd_en, rsp_valid}), 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_rd_en && !rsp_valid, "R1 idle after reset",
              int'({req_ready, mem_rd_en, rsp_valid}), 3'b100);

        // R6: stray read data in IDLE is ignored
        stray_req = 1;
        repeat (4) begin
            @(negedge clk);
            check(req_ready && !rsp_valid && !mem_rd_en, "R6 stray data ignored",
                  int'({req_ready, rsp_valid, mem_rd_en}), 3'b100);
        end
        stray_req = 0;

        // exhaustive page sweep, several offsets and latencies
        k = 0;
        for (int p = 0; p < 64; p++) begin
            for (int o = 0; o < 3; o++) begin
                logic [9:0] off;
                off = (o == 0) ? 10'd0 : ((o == 1) ? 10'd1023 : 10'((p * 37) % 1024));
                translate({6'(p), off}, (k % 5) + 1, (p % 3) == 0);
                k++;
            end
        end

        // R6: long memory latency
        translate({3'd2, 3'd4, 10'h155}, 40, 1'b0);
        translate({3'd5, 3'd1, 10'h2AA}, 25, 1'b1);
        summary();
    end
endmodule